// File: doc/BRIEF.md
# Four-Bank Interleaved Texel Cache

A read-only texture cache that hands a bilinear filter four 32-bit texels per request over a 128-bit bus. The line storage is spread word by word over four single-ported data banks: bank b keeps word b of every line. Address steering sends each texel address to the bank that owns it. An output crossbar of four 32-bit 4-to-1 selectors then puts each bank word into the output slot that belongs to its requesting address.

One tag comparator decides hit or miss. A multiplexer places the tag of the lead pending texel in front of it. Every pending texel in the same line as the lead texel is served in that lookup cycle, so each further distinct line costs one extra cycle while `busy` stays high. A bank that no served texel maps to stays disabled, which saves access energy.

On a miss the block asks for the whole line over a fill request/response pair. It writes the returned 128 bits into all four banks in one cycle and then replays the lookup. The cache is direct-mapped with 16 lines.

Top module: `banked_texel_cache`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `fill_req` and `bank_en` are low and every line is invalid, so the first access to any address, address 0 included, needs a fill and reports `rsp_hit`=0.
- R2: The byte address splits into bank select bits [3:2], line index bits [7:4] and tag bits [31:8]. Output slot i (`rsp_texels` bits 32i+31:32i) carries the word at the address in `req_addr` slot i (bits 32i+31:32i), whichever bank supplied it.
- R3: Bank b stores word b of each line. In a fill, `fill_data` bits 32w+31:32w are the word at line base + 4w, and a later request returns exactly those words.
- R4: A request is accepted on an edge where `req_valid` is high and `busy` is low. When all four texels lie in one resident line, `rsp_valid` is high after the second clock edge following the accepting edge.
- R5: Each additional distinct resident line in a request adds one cycle of latency. `busy` is high from the edge after acceptance until the response, and low in the response cycle.
- R6: Only banks owning a word of the request are read. `bank_en` bit b is high in the cycle after bank b is read and is zero while `busy` is low. Over a request, the set of `bank_en` bits is exactly the set of banks owning its texels.
- R7: On a miss, `fill_req` rises with `fill_addr` set to the line base (low four bits zero). Both hold until `fill_valid` is seen. The line is then written in that cycle and the lookup is replayed, so a second request to the same line needs no fill.
- R8: A fill replaces the single line at its index (direct mapping), which can evict a line needed later in the same request. `rsp_hit` is 1 only if the request needed no fill.
- R9: `rsp_valid` is a one-cycle pulse, and `rsp_texels` and `rsp_hit` hold their values until the next response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_addr | input | 128 | Four texel byte addresses, slot i in bits 32i+31:32i |
| busy | output | 1 | Request in progress, new requests not taken |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_texels | output | 128 | Four texels, slot i for address slot i |
| rsp_hit | output | 1 | Response needed no fill |
| bank_en | output | 4 | Per-bank read enable, one cycle after the read |
| fill_req | output | 1 | Line fill wanted |
| fill_addr | output | 32 | Base byte address of the wanted line |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | 128 | Returned line, word w in bits 32w+31:32w |

## Verification
The lookup path is driven with four sequential words of one line, the same line reversed, one address repeated four times, and two words each repeated twice. These patterns separate correct slot steering from a fixed bank-to-slot wiring, and show whether unused banks stay disabled. Requests whose texels span two and four lines, including two lines competing for one bank, exercise the multi-cycle serve and the latency it adds. Two tags on one index inside a single request show eviction and replay. A delayed fill response shows that the request holds. A reset after traffic shows that all lines are invalidated.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_FIN
  } btc_state_t;
endpackage

// File: rtl/btc_bank.sv
module btc_bank #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/btc_tags.sv
module btc_tags #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  // selected tag feeds the single comparator
  assign hit = valid_q[look_idx] && (tag_mem[look_idx] == look_tag);
endmodule

// File: rtl/btc_xbar.sv
module btc_xbar #(
  parameter int WORD_W = 32,
  parameter int NBANK  = 4,
  localparam int SEL_W = $clog2(NBANK)
) (
  input  logic [NBANK*WORD_W-1:0] bank_data,
  input  logic [NBANK*SEL_W-1:0]  sel,
  output logic [NBANK*WORD_W-1:0] lane_data
);
  for (genvar l = 0; l < NBANK; l++) begin : g_lane
    logic [SEL_W-1:0] s;
    assign s = sel[l*SEL_W +: SEL_W];
    assign lane_data[l*WORD_W +: WORD_W] = bank_data[s*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/banked_texel_cache.sv
module banked_texel_cache
  import btc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int NBANK  = 4,
  parameter int LINES  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [NBANK*ADDR_W-1:0] req_addr,
  output logic                    busy,
  output logic                    rsp_valid,
  output logic [NBANK*WORD_W-1:0] rsp_texels,
  output logic                    rsp_hit,
  output logic [NBANK-1:0]        bank_en,
  output logic                    fill_req,
  output logic [ADDR_W-1:0]       fill_addr,
  input  logic                    fill_valid,
  input  logic [NBANK*WORD_W-1:0] fill_data
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int BSEL_W = $clog2(NBANK);
  localparam int OFF_W  = BYTE_W + BSEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  btc_state_t state_q;
  logic [ADDR_W-1:0] addr_q [NBANK];
  logic [WORD_W-1:0] acc_q  [NBANK];
  logic [NBANK-1:0]  pend_q, served_q, same, rd_en;
  logic              miss_q;
  logic [BSEL_W-1:0] lead;
  logic [LINE_W-1:0] lead_line;
  logic              lead_hit;
  logic              fill_we;
  logic [NBANK*WORD_W-1:0] bank_rdata, lane_word;
  logic [NBANK*BSEL_W-1:0] lane_sel;

  // lowest pending slot leads the lookup
  always_comb begin
    lead = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (pend_q[i]) lead = BSEL_W'(i);
    lead_line = addr_q[lead][ADDR_W-1:OFF_W];
  end

  // every pending slot in the lead line is served together
  always_comb begin
    rd_en = '0;
    for (int i = 0; i < NBANK; i++) begin
      same[i] = pend_q[i] && (addr_q[i][ADDR_W-1:OFF_W] == lead_line);
      if (state_q == ST_LOOK && lead_hit && same[i])
        rd_en[addr_q[i][OFF_W-1:BYTE_W]] = 1'b1;
    end
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_sel
    assign lane_sel[i*BSEL_W +: BSEL_W] = addr_q[i][OFF_W-1:BYTE_W];
  end

  assign fill_we = (state_q == ST_FILL) && fill_valid;

  btc_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .look_idx (lead_line[IDX_W-1:0]),
    .look_tag (lead_line[LINE_W-1:IDX_W]),
    .hit      (lead_hit),
    .wr_en    (fill_we),
    .wr_idx   (fill_addr[OFF_W +: IDX_W]),
    .wr_tag   (fill_addr[ADDR_W-1:OFF_W+IDX_W])
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    btc_bank #(.WORD_W(WORD_W), .DEPTH(LINES)) u_bank (
      .clk     (clk),
      .rd_en   (rd_en[b]),
      .rd_idx  (lead_line[IDX_W-1:0]),
      .rd_data (bank_rdata[b*WORD_W +: WORD_W]),
      .wr_en   (fill_we),
      .wr_idx  (fill_addr[OFF_W +: IDX_W]),
      .wr_data (fill_data[b*WORD_W +: WORD_W])
    );
  end

  btc_xbar #(.WORD_W(WORD_W), .NBANK(NBANK)) u_xbar (
    .bank_data (bank_rdata),
    .sel       (lane_sel),
    .lane_data (lane_word)
  );

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && req_valid)
      for (int i = 0; i < NBANK; i++) addr_q[i] <= req_addr[i*ADDR_W +: ADDR_W];
    for (int i = 0; i < NBANK; i++)
      if (served_q[i]) acc_q[i] <= lane_word[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_texels <= '0;
      fill_req   <= 1'b0;
      fill_addr  <= '0;
      pend_q     <= '0;
      served_q   <= '0;
      miss_q     <= 1'b0;
      bank_en    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      served_q  <= '0;
      bank_en   <= rd_en;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          busy    <= 1'b1;
          pend_q  <= '1;
          miss_q  <= 1'b0;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (lead_hit) begin
          served_q <= same;
          pend_q   <= pend_q & ~same;
          if ((pend_q & ~same) == '0) state_q <= ST_FIN;
        end else begin
          miss_q    <= 1'b1;
          fill_req  <= 1'b1;
          fill_addr <= {lead_line, {OFF_W{1'b0}}};
          state_q   <= ST_FILL;
        end
        ST_FILL: if (fill_valid) begin
          fill_req <= 1'b0;
          state_q  <= ST_LOOK;
        end
        default: begin
          rsp_valid <= 1'b1;
          busy      <= 1'b0;
          rsp_hit   <= !miss_q;
          for (int i = 0; i < NBANK; i++)
            rsp_texels[i*WORD_W +: WORD_W] <= served_q[i] ?
              lane_word[i*WORD_W +: WORD_W] : acc_q[i];
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/banked_texel_cache_chk.sv
module banked_texel_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int NBANK  = 4,
  parameter int LINES  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_valid,
  input logic [NBANK-1:0]  bank_en,
  input logic              fill_req,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              fill_valid
);
  localparam int OFF_W = $clog2(WORD_W / 8) + $clog2(NBANK);

  // R7
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fill_req && !fill_valid |=> fill_req && $stable(fill_addr));

  // R7
  fill_align_chk: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> fill_addr[OFF_W-1:0] == '0 && busy);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R5
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  // R4
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !busy |=> busy);

  // R6
  bank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> bank_en == '0);
endmodule

bind banked_texel_cache banked_texel_cache_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NBANK(NBANK), .LINES(LINES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .bank_en    (bank_en),
  .fill_req   (fill_req),
  .fill_addr  (fill_addr),
  .fill_valid (fill_valid)
);

// File: tb/banked_texel_cache_bench.sv
module banked_texel_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // {a0, a1, a2, a3, expected hit, expected bank set}
  localparam logic [132:0] VEC [NV] = '{
    {32'h100, 32'h104, 32'h108, 32'h10C, 1'b0, 4'hF},
    {32'h10C, 32'h108, 32'h104, 32'h100, 1'b1, 4'hF},
    {32'h104, 32'h104, 32'h104, 32'h104, 1'b1, 4'h2},
    {32'h100, 32'h108, 32'h100, 32'h108, 1'b1, 4'h5},
    {32'h200, 32'h104, 32'h20C, 32'h108, 1'b0, 4'hF},
    {32'h110, 32'h124, 32'h138, 32'h14C, 1'b0, 4'hF},
    {32'h110, 32'h124, 32'h138, 32'h14C, 1'b1, 4'hF},
    {32'h114, 32'h124, 32'h114, 32'h124, 1'b1, 4'h2},
    {32'h100, 32'h100, 32'h100, 32'h100, 1'b1, 4'h1},
    {32'h0FC, 32'h0F8, 32'h0F4, 32'h0F0, 1'b0, 4'hF}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [127:0] req_addr;
  logic         busy, rsp_valid, rsp_hit, fill_req;
  logic [127:0] rsp_texels;
  logic [3:0]   bank_en;
  logic [31:0]  fill_addr;
  logic         fill_valid;
  logic [127:0] fill_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [127:0] got_tex;
  logic         got_hit;
  logic [3:0]   got_banks;
  int           got_lat, got_fills;
  bit           busy_ok, hold_ok;
  logic [31:0]  last_fill_addr;

  banked_texel_cache u_banked_texel_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_texels(rsp_texels),
    .rsp_hit(rsp_hit), .bank_en(bank_en), .fill_req(fill_req),
    .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return ({2'b00, a[31:2]} * 32'h9E37_79B1) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [127:0] expect_tex(input logic [31:0] a0, a1, a2, a3);
    return {word_at(a3), word_at(a2), word_at(a1), word_at(a0)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] a0, a1, a2, a3, input int fill_delay);
    int k = 0;
    int wait_cnt = 0;
    logic [31:0] seen_addr = '0;
    got_banks = '0; got_fills = 0; busy_ok = 1'b1; hold_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {a3, a2, a1, a0};
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && k < 300) begin
      got_banks |= bank_en;
      if (!busy) busy_ok = 1'b0;
      if (fill_valid) fill_valid = 1'b0;
      else if (fill_req) begin
        if (wait_cnt == 0) seen_addr = fill_addr;
        else if (fill_addr != seen_addr) hold_ok = 1'b0;
        if (wait_cnt < fill_delay) wait_cnt++;
        else begin
          last_fill_addr = fill_addr;
          for (int w = 0; w < 4; w++)
            fill_data[w*32 +: 32] = word_at(fill_addr + 32'(4 * w));
          fill_valid = 1'b1;
          got_fills++;
          wait_cnt = 0;
        end
      end
      @(negedge clk);
      k++;
    end
    if (!rsp_valid) check(1'b0, "R4 response timeout", 128'(k), 128'(300));
    got_lat = k;
    got_tex = rsp_texels;
    got_hit = rsp_hit;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0;
    fill_valid = 1'b0; fill_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !rsp_valid && !fill_req && bank_en == 4'h0, "R1 reset outputs",
          {busy, rsp_valid, fill_req, bank_en}, 128'h0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      run_req(VEC[v][132:101], VEC[v][100:69], VEC[v][68:37], VEC[v][36:5], 0);
      // R2 slot steering
      check(got_tex == expect_tex(VEC[v][132:101], VEC[v][100:69], VEC[v][68:37], VEC[v][36:5]),
            $sformatf("R2 texels vec%0d", v), got_tex,
            expect_tex(VEC[v][132:101], VEC[v][100:69], VEC[v][68:37], VEC[v][36:5]));
      // R8 hit flag
      check(got_hit == VEC[v][4], $sformatf("R8 hit vec%0d", v), 128'(got_hit), 128'(VEC[v][4]));
      // R6 bank set
      check(got_banks == VEC[v][3:0], $sformatf("R6 banks vec%0d", v),
            128'(got_banks), 128'(VEC[v][3:0]));
    end

    // R4 one resident line
    run_req(32'h10C, 32'h108, 32'h104, 32'h100, 0);
    check(got_lat == 2 && got_hit, "R4 one-line latency", 128'(got_lat), 128'(2));
    check(busy_ok, "R5 busy held", 128'(busy_ok), 128'(1));
    // R9 pulse and hold
    @(negedge clk);
    check(!rsp_valid && rsp_texels == got_tex, "R9 pulse and hold",
          rsp_texels, got_tex);

    // R5 two lines sharing bank 1
    run_req(32'h114, 32'h124, 32'h114, 32'h124, 0);
    check(got_lat == 3, "R5 two-line latency", 128'(got_lat), 128'(3));
    // R5 four lines
    run_req(32'h110, 32'h124, 32'h138, 32'h14C, 0);
    check(got_lat == 5 && busy_ok, "R5 four-line latency", 128'(got_lat), 128'(5));

    // R7 delayed fill
    run_req(32'h3A8, 32'h3A8, 32'h3A8, 32'h3A8, 5);
    check(last_fill_addr == 32'h3A0, "R7 fill address", 128'(last_fill_addr), 128'h3A0);
    check(got_fills == 1 && hold_ok, "R7 fill held", 128'(got_fills), 128'(1));
    check(got_tex == expect_tex(32'h3A8, 32'h3A8, 32'h3A8, 32'h3A8) && !got_hit,
          "R7 replay data", got_tex, expect_tex(32'h3A8, 32'h3A8, 32'h3A8, 32'h3A8));
    // R3 line placement
    run_req(32'h3A0, 32'h3A4, 32'h3AC, 32'h3A8, 0);
    check(got_tex == expect_tex(32'h3A0, 32'h3A4, 32'h3AC, 32'h3A8), "R3 word placement",
          got_tex, expect_tex(32'h3A0, 32'h3A4, 32'h3AC, 32'h3A8));
    check(got_fills == 0 && got_hit, "R7 no refill", 128'(got_fills), 128'(0));

    // R1 reset invalidates
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    run_req(32'h3A8, 32'h3A8, 32'h3A8, 32'h3A8, 0);
    check(!got_hit && got_fills == 1, "R1 invalid after reset", 128'(got_hit), 128'(0));
    run_req(32'h000, 32'h004, 32'h008, 32'h00C, 0);
    check(!got_hit && got_tex == expect_tex(32'h000, 32'h004, 32'h008, 32'h00C),
          "R1 address zero misses", 128'(got_hit), 128'(0));

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule